// File: doc/BRIEF.md
# Float Compare, Select and Sign Unit

This execution unit handles the simple operations of a microcoded single-precision vector datapath. It works directly on the IEEE-754 bit patterns of its operands and contains no adder, multiplier or converter. Each cycle a 4-bit opcode, two 32-bit operands A and B, and a 32-bit flags word may be presented with `valid_i`. One clock later the unit returns a 32-bit result with a valid tag. An error flag is raised when the opcode belongs to an operation this unit does not implement.

The implemented operations are magnitude (absolute value), pass-through of A, greater-than and equality compares, flag-driven select, sign transfer, and the integer-trick seed for the reciprocal square root. The compares return the floating-point constants 1.0 (0x3F800000) or 0.0 rather than a single bit, so that their results can feed later arithmetic directly. The select is steered by the separate flags word and not by either operand.

Top module: `fcs_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `err_o` and `result_o` are all zero.
- R2: `valid_o` equals `valid_i` of the previous clock, and `result_o`/`err_o` reflect the opcode and operands sampled at that edge (one register stage).
- R3: When `valid_i` is low, `result_o` keeps its previous value and `valid_o` and `err_o` are 0 on the next cycle.
- R4: Opcode 10 (greater-than) returns 0x3F800000 when A > B as floats and 0x00000000 otherwise. +0 and -0 compare equal. Any NaN operand (exponent field all ones, fraction nonzero) yields 0.
- R5: Opcode 11 (equality) returns 0x3F800000 when A == B as floats and 0 otherwise. +0 equals -0, and any NaN operand yields 0.
- R6: Opcode 4 returns A with bit 31 cleared. Opcode 12 returns A unchanged.
- R7: Opcode 13 returns A when the flags word is nonzero, and B when it is zero.
- R8: Opcode 14 returns A with bit 31 inverted when B is less than zero (sign set, nonzero magnitude, not NaN), and A unchanged otherwise.
- R9: Opcode 15 returns 0x5F3759DF minus (A logically shifted right by one), modulo 2^32.
- R10: Opcode 0 returns 0 with `err_o` low. Opcodes 1, 2, 3, 5, 6, 7, 8 and 9 return 0 with `err_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| op_i | input | 4 | Opcode |
| a_i | input | 32 | Operand A, IEEE-754 single bits |
| b_i | input | 32 | Operand B, IEEE-754 single bits |
| flags_i | input | 32 | Flags word steering the select |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Registered result |
| err_o | output | 1 | Opcode not implemented by this unit |

## Verification
The bench sweeps every opcode over all pairs drawn from a set of sixteen special operands: signed zeros, ones, twos, halves, denormals, infinities, quiet and signalling NaNs, and the largest finite value. It rotates the flags word through zero, one and the sign bit. A unit that compared raw bit patterns would report -0 below +0 or call them unequal. A sign-blind magnitude compare would order negative pairs backwards. A compare that ignored NaN would return 1.0 for NaN against infinity. A sign transfer that looked only at bit 31 of B would negate A for a -0 or negative NaN steering operand. Idle cycles placed after the sweep catch a result register that reloads without `valid_i`.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_MUL  = 4'd3,
    OP_ABS  = 4'd4,
    OP_F2I  = 4'd5,
    OP_I2F  = 4'd6,
    OP_VOUT = 4'd7,
    OP_SIN  = 4'd8,
    OP_COS  = 4'd9,
    OP_GT   = 4'd10,
    OP_EQ   = 4'd11,
    OP_COPY = 4'd12,
    OP_SEL  = 4'd13,
    OP_SGN  = 4'd14,
    OP_RSQ  = 4'd15
  } fcs_op_e;

  typedef struct packed {
    logic nan;
    logic zero;
    logic neg;
  } fcs_class_t;

endpackage

// File: rtl/fcs_classify.sv
module fcs_classify
  import fcs_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] val_i,
  output fcs_class_t        cls_o
);

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;

  assign exp_f = val_i[DATA_W-2 -: EXP_W];
  assign man_f = val_i[MAN_W-1:0];

  always_comb begin
    cls_o.neg  = val_i[DATA_W-1];
    cls_o.nan  = (&exp_f) && (|man_f);
    cls_o.zero = ~|val_i[DATA_W-2:0];
  end

endmodule

// File: rtl/fcs_compare.sv
module fcs_compare
  import fcs_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  fcs_class_t        ca_i,
  input  fcs_class_t        cb_i,
  output logic              gt_o,
  output logic              eq_o
);

  logic [DATA_W-2:0] mag_a, mag_b;
  logic              any_nan, both_zero, ord_gt;

  assign mag_a     = a_i[DATA_W-2:0];
  assign mag_b     = b_i[DATA_W-2:0];
  assign any_nan   = ca_i.nan | cb_i.nan;
  assign both_zero = ca_i.zero & cb_i.zero;

  // sign-magnitude ordering; equal zeros never order
  always_comb begin
    unique case ({ca_i.neg, cb_i.neg})
      2'b01:   ord_gt = !both_zero;
      2'b10:   ord_gt = 1'b0;
      2'b00:   ord_gt = mag_a > mag_b;
      default: ord_gt = mag_a < mag_b;
    endcase
  end

  assign gt_o = !any_nan && ord_gt;
  assign eq_o = !any_nan && (both_zero || (a_i == b_i));

endmodule

// File: rtl/fcs_sign.sv
module fcs_sign
  import fcs_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  fcs_class_t        cb_i,
  output logic [DATA_W-1:0] abs_o,
  output logic [DATA_W-1:0] xfer_o
);

  logic b_below_zero;

  assign b_below_zero = cb_i.neg && !cb_i.zero && !cb_i.nan;
  assign abs_o        = {1'b0, a_i[DATA_W-2:0]};
  assign xfer_o       = {a_i[DATA_W-1] ^ b_below_zero, a_i[DATA_W-2:0]};

endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
  import fcs_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter logic [EXP_W+MAN_W:0] RSQ_MAGIC = 32'h5F3759DF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [3:0]  op_i,
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  logic [EXP_W+MAN_W:0] flags_i,
  output logic        valid_o,
  output logic [EXP_W+MAN_W:0] result_o,
  output logic        err_o
);

  localparam int DATA_W = 1 + EXP_W + MAN_W;
  localparam logic [DATA_W-1:0] FP_ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic [1:0][DATA_W-1:0] opnd;
  fcs_class_t             cls [2];
  logic                   gt, eq;
  logic [DATA_W-1:0]      abs_v, xfer_v, rsq_v;
  logic [DATA_W-1:0]      res_d;
  logic                   err_d;

  assign opnd[0] = a_i;
  assign opnd[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcs_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cls (
      .val_i (opnd[g]),
      .cls_o (cls[g])
    );
  end

  fcs_compare #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_cmp (
    .a_i  (a_i),
    .b_i  (b_i),
    .ca_i (cls[0]),
    .cb_i (cls[1]),
    .gt_o (gt),
    .eq_o (eq)
  );

  fcs_sign #(.EXP_W(EXP_W), .MAN_W(MAN_W)) i_sgn (
    .a_i    (a_i),
    .cb_i   (cls[1]),
    .abs_o  (abs_v),
    .xfer_o (xfer_v)
  );

  assign rsq_v = RSQ_MAGIC - (a_i >> 1);

  always_comb begin
    res_d = '0;
    err_d = 1'b0;
    case (fcs_op_e'(op_i))
      OP_NOP:  res_d = '0;
      OP_ABS:  res_d = abs_v;
      OP_GT:   res_d = gt ? FP_ONE : '0;
      OP_EQ:   res_d = eq ? FP_ONE : '0;
      OP_COPY: res_d = a_i;
      OP_SEL:  res_d = (|flags_i) ? a_i : b_i;
      OP_SGN:  res_d = xfer_v;
      OP_RSQ:  res_d = rsq_v;
      default: err_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i && err_d;
      if (valid_i) result_o <= res_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i && rst_ni));

  // R10
  err_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);

  // R10
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (result_o == '0));

  // R3
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && !err_o));

  // R4
  cmp_bool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && rst_ni && (op_i == OP_GT || op_i == OP_EQ)))
      |-> (result_o == FP_ONE || result_o == '0));

  // R6
  abs_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && rst_ni && op_i == OP_ABS)) |-> !result_o[DATA_W-1]);

endmodule

// File: tb/test_fcs_unit.sv
`timescale 1ns/1ps
module test_fcs_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, flags_i = '0;
  logic        valid_o, err_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fcs_unit i_fcs_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
    .valid_o(valid_o), .result_o(result_o), .err_o(err_o)
  );

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h00000000;  1: return 32'h80000000;
      2: return 32'h3F800000;  3: return 32'hBF800000;
      4: return 32'h40000000;  5: return 32'hC0000000;
      6: return 32'h00000001;  7: return 32'h80000001;
      8: return 32'h7F800000;  9: return 32'hFF800000;
      10: return 32'h7FC00000; 11: return 32'hFFC00001;
      12: return 32'h7F7FFFFF; 13: return 32'h3F000000;
      14: return 32'hBF000000; default: return 32'h7F800001;
    endcase
  endfunction

  function automatic bit is_nan(input logic [31:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 0);
  endfunction

  // total-order key: negative values map below zero, both zeros to 0
  function automatic longint key(input logic [31:0] v);
    longint m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      4, 12: return "R6";
      10: return "R4";
      11: return "R5";
      13: return "R7";
      14: return "R8";
      15: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [32:0] model(input int op, input logic [31:0] a,
                                         input logic [31:0] b, input logic [31:0] f);
    bit nan_any = is_nan(a) || is_nan(b);
    case (op)
      0: return 33'h0;
      4: return {1'b0, a & 32'h7FFFFFFF};                                   // R6
      10: return {1'b0, (!nan_any && key(a) > key(b)) ? 32'h3F800000 : 32'h0}; // R4
      11: return {1'b0, (!nan_any && key(a) == key(b)) ? 32'h3F800000 : 32'h0}; // R5
      12: return {1'b0, a};
      13: return {1'b0, (f != 0) ? a : b};                                   // R7
      14: return {1'b0, (!is_nan(b) && key(b) < 0) ? (a ^ 32'h80000000) : a}; // R8
      15: return {1'b0, 32'h5F3759DF - {1'b0, a[31:1]}};                     // R9
      default: return {1'b1, 32'h0};                                         // R10
    endcase
  endfunction

  task automatic check(input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual err=%0b res=%08h expected err=%0b res=%08h",
               req, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic run_one(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] f);
    valid_i = 1'b1; op_i = op[3:0]; a_i = a; b_i = b; flags_i = f;
    @(posedge clk); @(negedge clk);
    check("R2", {32'h0, valid_o}, 33'h1);
    check(req_of(op), {err_o, result_o}, model(op, a, b, f));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] last;
    valid_i = 1'b1; op_i = 4'd12; a_i = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    // R1
    check("R1", {valid_o, result_o}, 33'h0);
    check("R1", {32'h0, err_o}, 33'h0);
    valid_i = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          logic [31:0] f;
          case ((i + j + op) % 3)
            0: f = 32'h0;
            1: f = 32'h1;
            default: f = 32'h80000000;
          endcase
          run_one(op, pick(i), pick(j), f);
        end

    // R3: idle cycles keep the last result
    run_one(12, 32'h12345678, 32'h0, 32'h0);
    last = result_o;
    for (int k = 0; k < 8; k++) begin
      valid_i = 1'b0; op_i = 4'(k + 1); a_i = pick(k); b_i = pick(15 - k); flags_i = 32'(k);
      @(posedge clk); @(negedge clk);
      check("R3", {err_o, result_o}, {1'b0, last});
      check("R3", {32'h0, valid_o}, 33'h0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule